// File: doc/BRIEF.md
# Next-PC and Control-Transfer Unit

This unit decides where a 32-bit RISC core with fixed four-byte instructions fetches next. Each cycle it takes the current program counter, a three-bit code from the decoder naming the kind of control transfer, the low 26 bits of the instruction, and the value read from one source register. It then produces the next program counter and a flag that says whether the sequential path was left. For the two call-type forms it also produces a request to write the return address into the fixed link register.

PC-relative targets are formed by sign-extending an offset and adding it to PC+4. Unconditional jumps use the full 26-bit field. Conditional branches use its low 16 bits. The register-indirect forms take the target straight from the source register. A conditional branch tests that single register against zero; it does not compare two registers. All results are combinational. An optional register, chosen by a parameter, holds the program counter and loads the computed value on every clock.

Top module: `npc_unit`

## Requirements
- R1: With `flow_op` equal to 0 (sequential) or 7 (reserved), `next_pc` is `cur_pc`+4, `taken` is 0 and `link_we` is 0.
- R2: With `flow_op` equal to 1 (jump), `next_pc` is `cur_pc`+4 plus `offset_field[25:0]` sign-extended from bit 25, `taken` is 1 and `link_we` is 0.
- R3: With `flow_op` equal to 2 (jump and link), `next_pc` is the same target as in R2, `taken` is 1 and `link_we` is 1.
- R4: With `flow_op` equal to 3 (register jump), `next_pc` equals `src_val`, `taken` is 1 and `link_we` is 0.
- R5: With `flow_op` equal to 4 (register jump and link), `next_pc` equals `src_val`, `taken` is 1 and `link_we` is 1.
- R6: With `flow_op` equal to 5 (branch if zero), the branch is taken when `src_val` is 0. A taken branch goes to `cur_pc`+4 plus `offset_field[15:0]` sign-extended from bit 15. Otherwise `next_pc` is `cur_pc`+4 with `taken` 0. `link_we` is 0 in both cases.
- R7: With `flow_op` equal to 6 (branch if not zero), the branch is taken when `src_val` is nonzero, with the same target and fall-through as in R6.
- R8: A negative offset moves the target backward, and every sum wraps modulo 2^32. Bits 31:26 of an instruction never reach the unit.
- R9: With `REG_PC`=1, `pc_q` takes `RESET_PC` (default 0) on a rising edge while the synchronous active-high `rst` is high. Otherwise it takes the `next_pc` of the preceding cycle.
- R10: Whenever `link_we` is 1, `link_idx` is 31 and `link_data` is `cur_pc`+4. `link_we` is 1 only for codes 2 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional PC register |
| rst | input | 1 | Synchronous active-high reset |
| cur_pc | input | 32 | Program counter of the current instruction |
| flow_op | input | 3 | Control-transfer code from the decoder |
| offset_field | input | 26 | Low 26 instruction bits holding the offset |
| src_val | input | 32 | Value of the source register |
| next_pc | output | 32 | Address of the next instruction |
| taken | output | 1 | Sequential path left |
| link_we | output | 1 | Link register write request |
| link_idx | output | 5 | Link register index |
| link_data | output | 32 | Return address to write |
| pc_q | output | 32 | Registered program counter |

## Verification
On every cycle the assertions check the following:
- The unit falls back to PC+4 whenever nothing is taken.
- A link write always comes with a taken transfer and the fixed index and return address.
- Register jumps land exactly on the source value.
- The branch-if-zero decision follows the zero test.
- The PC register follows the previous next-PC.

Only the bench's sweeps can show the rest. These cover the signed arithmetic of the two offset widths, the backward targets, wrap-around at the top of the address space, and the reserved code acting as sequential.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [2:0] {
        FLOW_SEQ   = 3'd0,
        FLOW_JMP   = 3'd1,
        FLOW_JMPL  = 3'd2,
        FLOW_JREG  = 3'd3,
        FLOW_JREGL = 3'd4,
        FLOW_BRZ   = 3'd5,
        FLOW_BRNZ  = 3'd6,
        FLOW_RSVD  = 3'd7
    } flow_e;

    typedef struct packed {
        logic redirect;   // unconditional transfer
        logic link;       // write return address
        logic use_reg;    // target comes from register
        logic use_long;   // 26-bit offset instead of 16-bit
        logic cond;       // conditional on zero test
        logic want_zero;  // branch when register is zero
    } flow_ctl_t;

    function automatic flow_ctl_t decode_flow(flow_e op);
        flow_ctl_t c;
        c = '0;
        unique case (op)
            FLOW_JMP:   begin c.redirect = 1'b1; c.use_long = 1'b1; end
            FLOW_JMPL:  begin c.redirect = 1'b1; c.use_long = 1'b1; c.link = 1'b1; end
            FLOW_JREG:  begin c.redirect = 1'b1; c.use_reg = 1'b1; end
            FLOW_JREGL: begin c.redirect = 1'b1; c.use_reg = 1'b1; c.link = 1'b1; end
            FLOW_BRZ:   begin c.cond = 1'b1; c.want_zero = 1'b1; end
            FLOW_BRNZ:  begin c.cond = 1'b1; end
            default:    c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [2:0] op,
    output flow_ctl_t  ctl
);
    always_comb ctl = decode_flow(flow_e'(op));
endmodule

// File: rtl/npc_adder.sv
module npc_adder #(
    parameter int XLEN    = 32,
    parameter int LONG_W  = 26,
    parameter int SHORT_W = 16,
    parameter int STEP    = 4
) (
    input  logic [XLEN-1:0]   pc,
    input  logic [LONG_W-1:0] off,
    input  logic              use_long,
    output logic [XLEN-1:0]   seq_pc,
    output logic [XLEN-1:0]   rel_pc
);
    localparam int LPAD = XLEN - LONG_W;
    localparam int SPAD = XLEN - SHORT_W;

    logic [XLEN-1:0] off_long, off_short, off_sel;

    always_comb begin
        off_long  = {{LPAD{off[LONG_W-1]}}, off};
        off_short = {{SPAD{off[SHORT_W-1]}}, off[SHORT_W-1:0]};
        off_sel   = use_long ? off_long : off_short;
        seq_pc    = pc + XLEN'(STEP);
        rel_pc    = seq_pc + off_sel;
    end
endmodule

// File: rtl/npc_pick.sv
module npc_pick
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  flow_ctl_t       ctl,
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] seq_pc,
    input  logic [XLEN-1:0] rel_pc,
    output logic [XLEN-1:0] nxt,
    output logic            take,
    output logic            link
);
    logic is_zero;

    always_comb begin
        is_zero = (src == '0);
        take    = ctl.redirect | (ctl.cond & (is_zero == ctl.want_zero));
        link    = ctl.link;
        if (!take)           nxt = seq_pc;
        else if (ctl.use_reg) nxt = src;
        else                 nxt = rel_pc;
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          LONG_W   = 26,
    parameter int          SHORT_W  = 16,
    parameter int          STEP     = 4,
    parameter int          NREGS    = 32,
    parameter bit          REG_PC   = 1'b1,
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [XLEN-1:0]          cur_pc,
    input  logic [2:0]               flow_op,
    input  logic [LONG_W-1:0]        offset_field,
    input  logic [XLEN-1:0]          src_val,
    output logic [XLEN-1:0]          next_pc,
    output logic                     taken,
    output logic                     link_we,
    output logic [$clog2(NREGS)-1:0] link_idx,
    output logic [XLEN-1:0]          link_data,
    output logic [XLEN-1:0]          pc_q
);
    localparam int REG_W = $clog2(NREGS);
    localparam logic [REG_W-1:0] LINK_REG = REG_W'(NREGS - 1);

    flow_ctl_t       ctl;
    logic [XLEN-1:0] seq_pc, rel_pc;

    npc_decode u_dec (.op(flow_op), .ctl(ctl));

    npc_adder #(.XLEN(XLEN), .LONG_W(LONG_W), .SHORT_W(SHORT_W), .STEP(STEP)) u_add (
        .pc(cur_pc), .off(offset_field), .use_long(ctl.use_long),
        .seq_pc(seq_pc), .rel_pc(rel_pc)
    );

    npc_pick #(.XLEN(XLEN)) u_pick (
        .ctl(ctl), .src(src_val), .seq_pc(seq_pc), .rel_pc(rel_pc),
        .nxt(next_pc), .take(taken), .link(link_we)
    );

    assign link_idx  = LINK_REG;
    assign link_data = seq_pc;

    generate
        if (REG_PC) begin : g_pc_reg
            logic [XLEN-1:0] pc_r;
            always_ff @(posedge clk) begin
                if (rst) pc_r <= XLEN'(RESET_PC);
                else     pc_r <= next_pc;
            end
            assign pc_q = pc_r;

            // R9: register follows the previous next-PC
            a_r9_pc_capture: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> pc_q == $past(next_pc));
        end else begin : g_pc_comb
            assign pc_q = next_pc;
        end
    endgenerate

    // R1: fall-through address when nothing is taken
    a_r1_seq_when_idle: assert property (@(posedge clk) disable iff (rst)
        !taken |-> next_pc == cur_pc + XLEN'(STEP));

    // R3: a link write is always part of a taken transfer
    a_r3_link_implies_taken: assert property (@(posedge clk) disable iff (rst)
        link_we |-> taken);

    // R10: link request fields
    a_r10_link_fields: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (link_idx == LINK_REG && link_data == cur_pc + XLEN'(STEP)));

    // R4: register jumps land on the source value
    a_r4_reg_target: assert property (@(posedge clk) disable iff (rst)
        (flow_op == 3'd3 || flow_op == 3'd4) |-> (taken && next_pc == src_val));

    // R6: branch-if-zero decision follows the zero test
    a_r6_brz_decision: assert property (@(posedge clk) disable iff (rst)
        (flow_op == 3'd5) |-> (taken == (src_val == '0)));

endmodule

// File: tb/npc_unit_bench.sv
module npc_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] cur_pc;
    logic [2:0]  flow_op;
    logic [25:0] offset_field;
    logic [31:0] src_val;
    logic [31:0] next_pc;
    logic        taken;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_data;
    logic [31:0] pc_q;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    npc_unit u_npc_unit (
        .clk(clk), .rst(rst), .cur_pc(cur_pc), .flow_op(flow_op),
        .offset_field(offset_field), .src_val(src_val), .next_pc(next_pc),
        .taken(taken), .link_we(link_we), .link_idx(link_idx),
        .link_data(link_data), .pc_q(pc_q)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [31:0] rel_target(input logic [31:0] pc, input logic [25:0] f,
                                               input bit long_off);
        longint o;
        if (long_off) begin
            o = longint'(f);
            if (o >= 64'sd33554432) o = o - 64'sd67108864;
        end else begin
            o = longint'(f[15:0]);
            if (o >= 64'sd32768) o = o - 64'sd65536;
        end
        return 32'(longint'(pc) + 4 + o);
    endfunction

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        logic [31:0] pcs  [4];
        logic [25:0] offs [5];
        logic [31:0] srcs [4];
        pcs[0] = 32'h0000_0000; pcs[1] = 32'h0000_1000;
        pcs[2] = 32'hFFFF_FFFC; pcs[3] = 32'h8000_0000;
        offs[0] = 26'h000_0010; offs[1] = 26'h3FF_FFFC; offs[2] = 26'h200_0000;
        offs[3] = 26'h000_8000; offs[4] = 26'h1FF_7FF0;
        srcs[0] = 32'h0; srcs[1] = 32'h1; srcs[2] = 32'h8000_0000; srcs[3] = 32'hFFFF_FFFF;

        rst = 1'b1; cur_pc = '0; flow_op = '0; offset_field = '0; src_val = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pc_q == 32'h0, "R9 reset value", pc_q, 32'h0);

        // hold reset while a jump is presented: register must stay at reset value
        flow_op = 3'd1; offset_field = 26'h100;
        @(posedge clk); #1;
        check(pc_q == 32'h0, "R9 reset dominates", pc_q, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        for (int op = 0; op < 8; op++) begin
            for (int p = 0; p < 4; p++) begin
                for (int k = 0; k < 5; k++) begin
                    for (int s = 0; s < 4; s++) begin
                        logic [31:0] seq, exp_pc;
                        bit exp_take, exp_link;
                        @(negedge clk);
                        flow_op = 3'(op); cur_pc = pcs[p]; offset_field = offs[k]; src_val = srcs[s];
                        seq = pcs[p] + 32'd4;
                        case (op)
                            1: begin exp_take = 1; exp_link = 0; exp_pc = rel_target(pcs[p], offs[k], 1); end // R2 R8
                            2: begin exp_take = 1; exp_link = 1; exp_pc = rel_target(pcs[p], offs[k], 1); end // R3
                            3: begin exp_take = 1; exp_link = 0; exp_pc = srcs[s]; end                        // R4
                            4: begin exp_take = 1; exp_link = 1; exp_pc = srcs[s]; end                        // R5
                            5: begin exp_take = (srcs[s] == 0); exp_link = 0;                                  // R6
                                     exp_pc = exp_take ? rel_target(pcs[p], offs[k], 0) : seq; end
                            6: begin exp_take = (srcs[s] != 0); exp_link = 0;                                  // R7
                                     exp_pc = exp_take ? rel_target(pcs[p], offs[k], 0) : seq; end
                            default: begin exp_take = 0; exp_link = 0; exp_pc = seq; end                       // R1
                        endcase
                        #2;
                        check(next_pc == exp_pc, $sformatf("R1-7 target op=%0d (R8 wrap/sign)", op), next_pc, exp_pc);
                        check(taken == exp_take, $sformatf("taken op=%0d R6 R7", op), 32'(taken), 32'(exp_take));
                        check(link_we == exp_link, $sformatf("R10 link_we op=%0d", op), 32'(link_we), 32'(exp_link));
                        if (exp_link) begin
                            check(link_idx == 5'd31, "R10 link index", 32'(link_idx), 32'd31);
                            check(link_data == seq, "R3 R5 link data", link_data, seq);
                        end
                        @(posedge clk); #1;
                        check(pc_q == exp_pc, "R9 pc capture", pc_q, exp_pc);
                    end
                end
            end
        end

        // R8: backward branch spot check, 16-bit offset -8 from 0x100
        @(negedge clk);
        flow_op = 3'd5; cur_pc = 32'h100; offset_field = 26'h3FF_FFF8; src_val = 32'h0;
        #2;
        check(next_pc == 32'h0000_00FC, "R8 backward branch", next_pc, 32'h0000_00FC);

        finish_run();
    end

endmodule